// File: doc/BRIEF.md
# PMBus Slave Address Resolution Unit

This block decides which 7-bit bus addresses a power-management slave answers to. The stored base address and the address-select pin codes combine into a single effective device address. The block holds that address in a register and recomputes it only when it is initialised or when the host sends an apply strobe. Beside the device address, the block also recognises two global addresses, an optional rail address shared by several devices or phases, an optional channel address that stands for one fixed page, and a fault address used while the non-volatile configuration fails its CRC check.

The block supports two ways of building the address. In the replace variant, the pin codes overwrite bit fields of the base address. In the add variant, a pin count from 0 to 8 is added to the base. The block sees the first byte of each transaction, with the address in bits 7:1 and the read/write flag in bit 0. One cycle later it reports whether that address matched, which class of address matched, and how the page should be chosen. A small write port loads the base, rail and channel registers. A recovery host can send a base-address write and then an apply strobe through the paged global address, which readdresses every device on the bus at once.

Top module: `pmb_addr_resolver`

## Requirements
- R1: The address is taken from bits 7:1 of `addr_byte_i` and the read/write flag from bit 0. Match results appear on the cycle after `addr_vld_i` is high, with `rw_o` equal to bit 0. When `addr_vld_i` is low, the next cycle shows `hit_o`=0, `kind_o`=0, `paged_o`=0, `fix_page_vld_o`=0 and `rw_o`=0.
- R2: In the replace variant, effective address bits 3:0 come from `pin_lo_code_i` when `pin_lo_vld_i` is 1. When that input is open, the bits come from base bits 3:0. With both pins open, the full 7-bit base is used.
- R3: In the replace variant with a second select input, effective address bits 6:4 come from `pin_hi_code_i` when `pin_hi_vld_i` is 1. Otherwise they come from base bits 6:4.
- R4: In the add variant, the effective address is base plus N modulo 128, with N = `pin_lo_code_i` when it is valid and no larger than 8. A code of 9 to 15, or an open pin, adds 0. The base resets to the factory value 0x5C.
- R5: The effective address changes only on the first cycle after reset, on `reinit_i`, or on `apply_i`. A base write alone leaves `eff_addr_o` unchanged. Recomputation uses the base value held before that cycle.
- R6: Address 0x5A always hits with `paged_o`=0, and 0x5B always hits with `paged_o`=1, unless a higher-priority class takes the same address.
- R7: The rail register resets to 0x80, which disables rail matching. Any other value makes its bits 6:0 a rail address that hits with `paged_o`=1.
- R8: The channel register resets to 0x80, which disables channel matching. Any other value makes its bits 6:0 a channel address. A channel hit gives `paged_o`=0, `fix_page_vld_o`=1 and `fix_page_o`=CHAN_PAGE.
- R9: `crc_bad_i` is sampled on initialisation (first cycle after reset, or `reinit_i`). While the sampled flag is set, the effective address is 0x7C in the replace variant and the factory base in the add variant. Apply strobes do not change it, and rail and channel matching are suppressed. The fault state clears only on a later initialisation with `crc_bad_i`=0.
- R10: When several classes match, the priority is device, then channel, then rail, then global. `kind_o` is one-hot, with bit0 device, bit1 channel, bit2 rail and bit3 global. `hit_o` is 1 exactly when one bit is set.
- R11: A write with `cfg_we_i`=1 uses `cfg_sel_i` to pick the target: 0 loads the base from `cfg_wdata_i[6:0]`, 1 loads the rail register, 2 loads the channel register, and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| reinit_i | input | 1 | Re-initialise strobe from the reset command |
| apply_i | input | 1 | Re-apply pins to the current base |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select for writes |
| cfg_wdata_i | input | 8 | Register write data |
| pin_lo_vld_i | input | 1 | Lower select pin carries a code |
| pin_lo_code_i | input | 4 | Lower select pin code |
| pin_hi_vld_i | input | 1 | Upper select pin carries a code |
| pin_hi_code_i | input | 3 | Upper select pin code |
| crc_bad_i | input | 1 | Configuration memory failed its CRC |
| addr_vld_i | input | 1 | Address byte present |
| addr_byte_i | input | 8 | Address byte after START |
| hit_o | output | 1 | Some address class matched |
| kind_o | output | 4 | One-hot matched class |
| paged_o | output | 1 | Command uses the page register |
| fix_page_vld_o | output | 1 | Page implied by the address |
| fix_page_o | output | PAGE_W | Implied page |
| rw_o | output | 1 | Read/write flag of the matched byte |
| eff_addr_o | output | 7 | Latched effective device address |

## Verification
If the latched address or the fault flag holds a wrong value, the error shows directly on `eff_addr_o` in the cycle after the initialisation or apply that produced it. It also shows one cycle after the next address byte, as a missed or wrong device hit. If a rail or channel register is corrupted, the error appears as a hit, a miss or a wrong `kind_o` on the first byte that targets that address. A priority fault shows only when two classes share one address, so the bench places those collisions deliberately. The replace and add variants run side by side on the same stimulus, so every wrong pin field or wrong sum shows up as a mismatch on `eff_addr_o`.

// File: rtl/pmb_addr_pkg.sv
package pmb_addr_pkg;

    localparam int ADDR_W = 7;
    localparam int LO_W   = 4;
    localparam int HI_W   = ADDR_W - LO_W;

    localparam logic [ADDR_W-1:0] GLOB_FLAT  = 7'h5A;
    localparam logic [ADDR_W-1:0] GLOB_PAGED = 7'h5B;
    localparam logic [ADDR_W-1:0] FAULT_ADDR = 7'h7C;
    localparam logic [7:0]        SLOT_OFF   = 8'h80;
    localparam logic [LO_W-1:0]   ADD_MAX    = 4'd8;

    localparam int K_DEV  = 0;
    localparam int K_CHAN = 1;
    localparam int K_RAIL = 2;
    localparam int K_GLOB = 3;
    localparam int K_N    = 4;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_RAIL = 2'd1,
        CFG_CHAN = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic           hit;
        logic [K_N-1:0] kind;
        logic           paged;
        logic           fixv;
        logic           rw;
    } match_t;

endpackage

// File: rtl/pmb_addr_compose.sv
module pmb_addr_compose
    import pmb_addr_pkg::*;
#(
    parameter bit              ADD_MODE = 1'b0,
    parameter bit              DUAL_SEL = 1'b1,
    parameter logic [ADDR_W-1:0] BASE_RST = 7'h5C
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              lo_vld_i,
    input  logic [LO_W-1:0]   lo_code_i,
    input  logic              hi_vld_i,
    input  logic [HI_W-1:0]   hi_code_i,
    input  logic              fault_i,
    output logic [ADDR_W-1:0] addr_o
);

    generate
        if (ADD_MODE) begin : g_add
            logic [LO_W-1:0] step;
            logic            unused_hi;
            assign unused_hi = ^{hi_vld_i, hi_code_i};
            always_comb begin
                step   = (lo_vld_i && (lo_code_i <= ADD_MAX)) ? lo_code_i : '0;
                addr_o = fault_i ? BASE_RST
                                 : base_i + {{(ADDR_W-LO_W){1'b0}}, step};
            end
        end else begin : g_rep
            logic [HI_W-1:0] top;
            logic [LO_W-1:0] bot;
            if (DUAL_SEL) begin : g_dual
                assign top = hi_vld_i ? hi_code_i : base_i[ADDR_W-1:LO_W];
            end else begin : g_single
                logic unused_hi;
                assign unused_hi = ^{hi_vld_i, hi_code_i};
                assign top = base_i[ADDR_W-1:LO_W];
            end
            assign bot    = lo_vld_i ? lo_code_i : base_i[LO_W-1:0];
            assign addr_o = fault_i ? FAULT_ADDR : {top, bot};
        end
    endgenerate

endmodule

// File: rtl/pmb_addr_match.sv
module pmb_addr_match
    import pmb_addr_pkg::*;
(
    input  logic              vld_i,
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] eff_i,
    input  logic [7:0]        rail_i,
    input  logic [7:0]        chan_i,
    input  logic              fault_i,
    output match_t            res_o
);

    logic [ADDR_W-1:0] a;
    logic dev_h, chan_h, rail_h, flat_h, paged_h;

    always_comb begin
        a       = byte_i[7:1];
        dev_h   = (a == eff_i);
        chan_h  = !fault_i && (chan_i != SLOT_OFF) && (a == chan_i[ADDR_W-1:0]);
        rail_h  = !fault_i && (rail_i != SLOT_OFF) && (a == rail_i[ADDR_W-1:0]);
        flat_h  = (a == GLOB_FLAT);
        paged_h = (a == GLOB_PAGED);

        res_o = '0;
        if (vld_i) begin
            res_o.rw = byte_i[0];
            if (dev_h) begin
                res_o.kind[K_DEV] = 1'b1;
                res_o.paged       = 1'b1;
            end else if (chan_h) begin
                res_o.kind[K_CHAN] = 1'b1;
                res_o.fixv         = 1'b1;
            end else if (rail_h) begin
                res_o.kind[K_RAIL] = 1'b1;
                res_o.paged        = 1'b1;
            end else if (flat_h || paged_h) begin
                res_o.kind[K_GLOB] = 1'b1;
                res_o.paged        = paged_h;
            end
            res_o.hit = |res_o.kind;
        end
    end

endmodule

// File: rtl/pmb_addr_resolver.sv
module pmb_addr_resolver
    import pmb_addr_pkg::*;
#(
    parameter bit                ADD_MODE  = 1'b0,
    parameter bit                DUAL_SEL  = 1'b1,
    parameter logic [ADDR_W-1:0] BASE_RST  = 7'h5C,
    parameter int                PAGE_W    = 2,
    parameter logic [PAGE_W-1:0] CHAN_PAGE = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit_i,
    input  logic              apply_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [7:0]        cfg_wdata_i,
    input  logic              pin_lo_vld_i,
    input  logic [3:0]        pin_lo_code_i,
    input  logic              pin_hi_vld_i,
    input  logic [2:0]        pin_hi_code_i,
    input  logic              crc_bad_i,
    input  logic              addr_vld_i,
    input  logic [7:0]        addr_byte_i,
    output logic              hit_o,
    output logic [3:0]        kind_o,
    output logic              paged_o,
    output logic              fix_page_vld_o,
    output logic [PAGE_W-1:0] fix_page_o,
    output logic              rw_o,
    output logic [6:0]        eff_addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] eff;
        logic [ADDR_W-1:0] base;
        logic [7:0]        rail;
        logic [7:0]        chan;
        logic              fault;
        logic              pend;
        match_t            res;
    } state_t;

    state_t st_d, st_q;

    logic              init_now;
    logic              fault_use;
    logic [ADDR_W-1:0] comp_addr;
    match_t            mres;
    cfg_sel_e          sel;

    assign init_now  = st_q.pend || reinit_i;
    assign fault_use = init_now ? crc_bad_i : st_q.fault;
    assign sel       = cfg_sel_e'(cfg_sel_i);

    pmb_addr_compose #(
        .ADD_MODE (ADD_MODE),
        .DUAL_SEL (DUAL_SEL),
        .BASE_RST (BASE_RST)
    ) u_compose (
        .base_i    (st_q.base),
        .lo_vld_i  (pin_lo_vld_i),
        .lo_code_i (pin_lo_code_i),
        .hi_vld_i  (pin_hi_vld_i),
        .hi_code_i (pin_hi_code_i),
        .fault_i   (fault_use),
        .addr_o    (comp_addr)
    );

    pmb_addr_match u_match (
        .vld_i   (addr_vld_i),
        .byte_i  (addr_byte_i),
        .eff_i   (st_q.eff),
        .rail_i  (st_q.rail),
        .chan_i  (st_q.chan),
        .fault_i (st_q.fault),
        .res_o   (mres)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        st_d.res  = mres;
        if (init_now) begin
            st_d.eff   = comp_addr;
            st_d.fault = crc_bad_i;
        end else if (apply_i) begin
            st_d.eff = comp_addr;
        end
        if (cfg_we_i) begin
            case (sel)
                CFG_BASE: st_d.base = cfg_wdata_i[ADDR_W-1:0];
                CFG_RAIL: st_d.rail = cfg_wdata_i;
                CFG_CHAN: st_d.chan = cfg_wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.eff   <= BASE_RST;
            st_q.base  <= BASE_RST;
            st_q.rail  <= SLOT_OFF;
            st_q.chan  <= SLOT_OFF;
            st_q.pend  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    logic dbg_pend_w, dbg_fault_w;
    assign dbg_pend_w  = st_q.pend;
    assign dbg_fault_w = st_q.fault;

    assign hit_o          = st_q.res.hit;
    assign kind_o         = st_q.res.kind;
    assign paged_o        = st_q.res.paged;
    assign fix_page_vld_o = st_q.res.fixv;
    assign fix_page_o     = st_q.res.fixv ? CHAN_PAGE : '0;
    assign rw_o           = st_q.res.rw;
    assign eff_addr_o     = st_q.eff;

endmodule

// File: rtl/pmb_addr_chk.sv
module pmb_addr_chk #(
    parameter bit ADD_MODE = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reinit_i,
    input logic       apply_i,
    input logic       addr_vld_i,
    input logic [7:0] addr_byte_i,
    input logic       hit_o,
    input logic [3:0] kind_o,
    input logic       paged_o,
    input logic       fix_page_vld_o,
    input logic       rw_o,
    input logic [6:0] eff_addr_o,
    input logic       pend,
    input logic       fault
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld_i |=> (!hit_o && kind_o == 4'd0 && !rw_o));

    assert_rw_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_i |=> (rw_o == $past(addr_byte_i[0])));

    assert_eff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_i && !reinit_i && !pend) |=> $stable(eff_addr_o));

    assert_glob_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_i && (addr_byte_i[7:1] == 7'h5A || addr_byte_i[7:1] == 7'h5B)) |=> hit_o);

    assert_chan_unpaged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kind_o[1] |-> (!paged_o && fix_page_vld_o));

    assert_fault_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !pend && !ADD_MODE) |-> (eff_addr_o == 7'h7C));

    assert_kind_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == ($countones(kind_o) == 1));

endmodule

bind pmb_addr_resolver pmb_addr_chk #(.ADD_MODE(ADD_MODE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reinit_i       (reinit_i),
    .apply_i        (apply_i),
    .addr_vld_i     (addr_vld_i),
    .addr_byte_i    (addr_byte_i),
    .hit_o          (hit_o),
    .kind_o         (kind_o),
    .paged_o        (paged_o),
    .fix_page_vld_o (fix_page_vld_o),
    .rw_o           (rw_o),
    .eff_addr_o     (eff_addr_o),
    .pend           (dbg_pend_w),
    .fault          (dbg_fault_w)
);

// File: tb/pmb_addr_resolver_tb.sv
module pmb_addr_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] BASE_RST = 7'h5C;
    localparam logic [1:0] CHAN_PAGE = 2'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reinit_i = 0, apply_i = 0, cfg_we_i = 0;
    logic [1:0] cfg_sel_i = 0;
    logic [7:0] cfg_wdata_i = 0;
    logic pin_lo_vld_i = 0, pin_hi_vld_i = 0, crc_bad_i = 0, addr_vld_i = 0;
    logic [3:0] pin_lo_code_i = 0;
    logic [2:0] pin_hi_code_i = 0;
    logic [7:0] addr_byte_i = 0;

    logic r_hit, r_paged, r_fixv, r_rw, a_hit, a_paged, a_fixv, a_rw;
    logic [3:0] r_kind, a_kind;
    logic [1:0] r_page, a_page;
    logic [6:0] r_eff, a_eff;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmb_addr_resolver #(.ADD_MODE(1'b0), .DUAL_SEL(1'b1), .BASE_RST(BASE_RST),
        .PAGE_W(2), .CHAN_PAGE(CHAN_PAGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reinit_i(reinit_i), .apply_i(apply_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .pin_lo_vld_i(pin_lo_vld_i), .pin_lo_code_i(pin_lo_code_i),
        .pin_hi_vld_i(pin_hi_vld_i), .pin_hi_code_i(pin_hi_code_i),
        .crc_bad_i(crc_bad_i), .addr_vld_i(addr_vld_i), .addr_byte_i(addr_byte_i),
        .hit_o(r_hit), .kind_o(r_kind), .paged_o(r_paged), .fix_page_vld_o(r_fixv),
        .fix_page_o(r_page), .rw_o(r_rw), .eff_addr_o(r_eff));

    pmb_addr_resolver #(.ADD_MODE(1'b1), .DUAL_SEL(1'b0), .BASE_RST(BASE_RST),
        .PAGE_W(2), .CHAN_PAGE(CHAN_PAGE)) u_add (
        .clk(clk), .rst_n(rst_n), .reinit_i(reinit_i), .apply_i(apply_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .pin_lo_vld_i(pin_lo_vld_i), .pin_lo_code_i(pin_lo_code_i),
        .pin_hi_vld_i(pin_hi_vld_i), .pin_hi_code_i(pin_hi_code_i),
        .crc_bad_i(crc_bad_i), .addr_vld_i(addr_vld_i), .addr_byte_i(addr_byte_i),
        .hit_o(a_hit), .kind_o(a_kind), .paged_o(a_paged), .fix_page_vld_o(a_fixv),
        .fix_page_o(a_page), .rw_o(a_rw), .eff_addr_o(a_eff));

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference model state
    logic [6:0] m_base, m_eff_r, m_eff_a;
    logic [7:0] m_rail, m_chan;
    logic m_crc, m_pend;

    function automatic logic [6:0] f_rep(logic [6:0] b, logic lv, logic [3:0] lc,
                                         logic hv, logic [2:0] hc, logic f);
        if (f) return 7'h7C;
        return {hv ? hc : b[6:4], lv ? lc : b[3:0]};
    endfunction

    function automatic logic [6:0] f_add(logic [6:0] b, logic lv, logic [3:0] lc, logic f);
        logic [6:0] n;
        if (f) return BASE_RST;
        n = (lv && lc <= 4'd8) ? {3'd0, lc} : 7'd0;
        return b + n;
    endfunction

    // {hit, kind[3:0], paged, fixv, rw, page[1:0]}
    function automatic logic [9:0] f_match(logic v, logic [7:0] by, logic [6:0] eff,
                                           logic [7:0] rl, logic [7:0] ch, logic f);
        logic [6:0] a;
        logic [3:0] k;
        logic pg, fx;
        a = by[7:1]; k = 0; pg = 0; fx = 0;
        if (!v) return 10'd0;
        if (a == eff) begin k = 4'b0001; pg = 1; end
        else if (!f && ch != 8'h80 && a == ch[6:0]) begin k = 4'b0010; fx = 1; end
        else if (!f && rl != 8'h80 && a == rl[6:0]) begin k = 4'b0100; pg = 1; end
        else if (a == 7'h5A) k = 4'b1000;
        else if (a == 7'h5B) begin k = 4'b1000; pg = 1; end
        return {k != 0, k, pg, fx, by[0], fx ? CHAN_PAGE : 2'd0};
    endfunction

    task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic tick(string tag);
        logic [9:0] e_r, e_a;
        logic init;
        logic f_use;
        e_r = f_match(addr_vld_i, addr_byte_i, m_eff_r, m_rail, m_chan, m_crc);
        e_a = f_match(addr_vld_i, addr_byte_i, m_eff_a, m_rail, m_chan, m_crc);
        init = m_pend || reinit_i;
        f_use = init ? crc_bad_i : m_crc;
        if (init || apply_i) begin
            m_eff_r = f_rep(m_base, pin_lo_vld_i, pin_lo_code_i, pin_hi_vld_i, pin_hi_code_i, f_use);
            m_eff_a = f_add(m_base, pin_lo_vld_i, pin_lo_code_i, f_use);
        end
        if (init) m_crc = crc_bad_i;
        m_pend = 0;
        if (cfg_we_i) begin
            case (cfg_sel_i)
                2'd0: m_base = cfg_wdata_i[6:0];
                2'd1: m_rail = cfg_wdata_i;
                2'd2: m_chan = cfg_wdata_i;
                default: ;
            endcase
        end
        @(posedge clk); #1;
        check(tag, "replace result", {6'd0, r_hit, r_kind, r_paged, r_fixv, r_rw, r_page}, {6'd0, e_r});
        check(tag, "add result",     {6'd0, a_hit, a_kind, a_paged, a_fixv, a_rw, a_page}, {6'd0, e_a});
        check(tag, "replace eff", {9'd0, r_eff}, {9'd0, m_eff_r});
        check(tag, "add eff",     {9'd0, a_eff}, {9'd0, m_eff_a});
        reinit_i = 0; apply_i = 0; cfg_we_i = 0; addr_vld_i = 0;
    endtask

    task automatic probe(string tag, logic [6:0] a, logic rw);
        addr_vld_i = 1; addr_byte_i = {a, rw};
        tick(tag);
    endtask

    task automatic wr(string tag, logic [1:0] s, logic [7:0] d);
        cfg_we_i = 1; cfg_sel_i = s; cfg_wdata_i = d;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_base = BASE_RST; m_eff_r = BASE_RST; m_eff_a = BASE_RST;
        m_rail = 8'h80; m_chan = 8'h80; m_crc = 0; m_pend = 1;
        pin_lo_vld_i = 1; pin_lo_code_i = 4'd3;
        repeat (3) @(posedge clk);
        #1;
        check("R5", "reset replace eff", {9'd0, r_eff}, {9'd0, BASE_RST});
        check("R1", "reset hit", {15'd0, r_hit | a_hit}, 16'd0);
        rst_n = 1;
        tick("R2");                 // init: 0x53 replace, 0x5F add
        check("R2", "init replace literal", {9'd0, r_eff}, 16'h0053);
        check("R4", "init add literal", {9'd0, a_eff}, 16'h005F);
        tick("R1");                 // idle
        probe("R1", 7'h53, 1'b1);
        pin_hi_vld_i = 1; pin_hi_code_i = 3'd2; apply_i = 1; tick("R3");
        check("R3", "upper field literal", {9'd0, r_eff}, 16'h0023);
        pin_lo_vld_i = 0; apply_i = 1; tick("R2");
        check("R2", "lower open literal", {9'd0, r_eff}, 16'h002C);
        wr("R11", 2'd0, 8'h11);
        tick("R5");
        check("R5", "base write held", {9'd0, r_eff}, 16'h002C);
        apply_i = 1; tick("R5");
        check("R5", "apply literal", {9'd0, r_eff}, 16'h0021);
        probe("R6", 7'h5A, 1'b0);
        probe("R6", 7'h5B, 1'b1);
        probe("R7", 7'h40, 1'b0);
        wr("R7", 2'd1, 8'h40);
        probe("R7", 7'h40, 1'b1);
        wr("R11", 2'd3, 8'h33);
        probe("R11", 7'h33, 1'b0);
        wr("R8", 2'd2, 8'h41);
        probe("R8", 7'h41, 1'b0);
        wr("R10", 2'd1, 8'h45); wr("R10", 2'd2, 8'h45);
        probe("R10", 7'h45, 1'b0);
        wr("R10", 2'd2, 8'h21);
        probe("R10", 7'h21, 1'b0);
        wr("R10", 2'd1, 8'h5B);
        probe("R10", 7'h5B, 1'b0);
        pin_lo_vld_i = 1; pin_lo_code_i = 4'd8; apply_i = 1; tick("R4");
        check("R4", "add eight literal", {9'd0, a_eff}, 16'h0019);
        pin_lo_code_i = 4'd9; apply_i = 1; tick("R4");
        check("R4", "add nine literal", {9'd0, a_eff}, 16'h0011);
        wr("R4", 2'd0, 8'h7E);
        pin_lo_code_i = 4'd8; apply_i = 1; tick("R4");
        check("R4", "add wrap literal", {9'd0, a_eff}, 16'h0006);
        crc_bad_i = 1; reinit_i = 1; tick("R9");
        check("R9", "fault replace literal", {9'd0, r_eff}, 16'h007C);
        check("R9", "fault add literal", {9'd0, a_eff}, {9'd0, BASE_RST});
        probe("R9", 7'h7C, 1'b1);
        probe("R9", 7'h5B, 1'b0);
        crc_bad_i = 0; apply_i = 1; tick("R9");
        probe("R9", 7'h7C, 1'b0);
        reinit_i = 1; tick("R9");
        probe("R9", m_eff_r, 1'b0);

        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            pin_lo_vld_i = r[0]; pin_lo_code_i = r[4:1];
            pin_hi_vld_i = r[5]; pin_hi_code_i = r[8:6];
            crc_bad_i = (r[15:12] == 0);
            apply_i = (r[19:16] < 2);
            reinit_i = (r[22:20] == 0) && (r[23]);
            cfg_we_i = (r[26:24] == 0);
            cfg_sel_i = r[28:27];
            cfg_wdata_i = (r[29]) ? 8'h80 : 8'($urandom);
            addr_vld_i = r[30];
            case ($urandom % 7)
                0: addr_byte_i = {m_eff_r, r[31]};
                1: addr_byte_i = {m_eff_a, r[31]};
                2: addr_byte_i = {m_rail[6:0], r[31]};
                3: addr_byte_i = {m_chan[6:0], r[31]};
                4: addr_byte_i = {7'h5A + 7'(r[31]), r[11]};
                5: addr_byte_i = {7'h7C, r[31]};
                default: addr_byte_i = 8'($urandom);
            endcase
            tick("R10");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule